// File: doc/BRIEF.md
# Microprogrammed Next-Address Sequencer

This block steps through a fixed control store in which every row carries two things. The first is a word of datapath control lines. The second is the address of the row that runs after it. There is no micro-program counter and no incrementer. The current row address sits in an address register. A one-hot row decoder reads that register and selects one row of a constant AND-OR matrix. The successor address is first captured in a separate holding register and only later copied into the address register. The decoder and the matrix are both combinational, so this second stage is what stops the current row from feeding straight back into its own select path.

A machine cycle is two clocks long. In the select phase the row strobe is high, the decoder drives its one-hot select, and the edge that ends the phase captures the successor into the holding register. In the transfer phase the strobe is low and the select lines are all quiet. The edge that ends this phase moves the holding register into the address register. One bit of the control word works as an instruction-register enable. When the active row asserts it, the holding register takes the first row of the execute routine for the current opcode instead of the row's own successor field. Rows 0 to 2 form the fetch routine. Each execute routine returns to row 0 when it finishes.

Top module: `ucode_sequencer`

## Requirements
- R1: Reset is synchronous. While reset is held, and in the first cycle after it is released, the address output is 0, the strobe is high, only select bit 0 is set, and the control output is 0x0001.
- R2: The strobe alternates high and low on every clock. The address and control outputs hold the same value across both clocks of a machine cycle. They change only on the edge that ends a strobe-low clock.
- R3: While the strobe is high, the select output is one-hot with its set bit at the index given by the address output. While the strobe is low, the select output is all zeros.
- R4: The control output is the control field of the current row. Fetch row r (r = 0, 1, 2) sets only bit r, and row 2 also sets bit 15, the dispatch enable. Step j of the execute routine for opcode k sets bit 3, holds k in bits 14:12 and j in bits 11:10, and sets bit 9 on the routine's final step. Rows that no routine uses have an all-zero control field.
- R5: Fetch runs as row 0, then row 1, then row 2, one machine cycle each.
- R6: The row after row 2 is the first row of the routine for the opcode present at the edge that ends row 2's strobe-high clock. That first row is 3 plus the sum of the routine lengths of all lower opcodes, which gives 3, 4, 6, 9, 10, 12, 15 and 16 for opcodes 0 to 7.
- R7: The routine for opcode k occupies (k mod 3) + 1 consecutive rows. Its final row is followed by row 0.
- R8: The opcode value at any edge other than the one named in R6 has no effect on the row sequence or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each machine cycle spans two rising edges |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 3 | Opcode from the instruction register, used for dispatch |
| ctrl_o | output | 16 | Control field of the current row |
| uaddr_o | output | 5 | Current row address (address register) |
| row_sel_o | output | 32 | One-hot row select, gated by the strobe |
| strobe_o | output | 1 | High during the select phase of the machine cycle |

## Verification
Each of the eight opcodes is run through a complete instruction with the opcode held steady. This confirms every dispatch target, every routine length and the return to fetch. A second sweep keeps the right opcode only at the dispatch edge and drives its complement at every other edge, which separates sampling at the correct edge from sampling one edge early or late. A third run changes the opcode on every clock in a scrambled order and ends with a reset in the middle of an instruction. This checks that the two-register timing and the reset value still hold when successive instructions differ.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int FETCH_ROWS = 3;

   typedef enum logic {
      PH_TRANSFER = 1'b0,
      PH_SELECT   = 1'b1
   } phase_e;

   function automatic int exec_len(input int k);
      return (k % 3) + 1;
   endfunction

   function automatic int exec_start(input int k);
      int s;
      s = FETCH_ROWS;
      for (int i = 0; i < k; i++) s += exec_len(i);
      return s;
   endfunction

   function automatic int rom_ctrl(input int r, input int n_opc, input int ire_bit);
      int c;
      c = 0;
      if (r < FETCH_ROWS) begin
         c = 1 << r;
         if (r == FETCH_ROWS - 1) c = c | (1 << ire_bit);
      end else begin
         for (int k = 0; k < n_opc; k++)
            for (int j = 0; j < exec_len(k); j++)
               if (exec_start(k) + j == r)
                  c = (k << 12) | (j << 10) | (1 << 3)
                      | ((j == exec_len(k) - 1) ? (1 << 9) : 0);
      end
      return c;
   endfunction

   function automatic int rom_next(input int r, input int n_opc);
      int n;
      n = 0;
      if (r < FETCH_ROWS - 1) begin
         n = r + 1;
      end else if (r >= FETCH_ROWS) begin
         for (int k = 0; k < n_opc; k++)
            for (int j = 0; j < exec_len(k) - 1; j++)
               if (exec_start(k) + j == r) n = r + 1;
      end
      return n;
   endfunction

endpackage

// File: rtl/useq_row_decoder.sv
module useq_row_decoder #(
   parameter int ADDR_W = 5,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   output logic [DEPTH-1:0]  sel_raw,
   output logic [DEPTH-1:0]  sel_gated
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign sel_raw[i]   = (addr == ADDR_W'(i));
      assign sel_gated[i] = sel_raw[i] & en;
   end

endmodule

// File: rtl/useq_ctrl_matrix.sv
module useq_ctrl_matrix #(
   parameter int CTRL_W  = 16,
   parameter int ADDR_W  = 5,
   parameter int N_OPC   = 8,
   parameter int IRE_BIT = 15,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic [DEPTH-1:0]  sel,
   output logic [CTRL_W-1:0] ctrl,
   output logic [ADDR_W-1:0] nxt
);
   import useq_pkg::*;

   localparam int WORD_W = CTRL_W + ADDR_W;

   logic [WORD_W-1:0] lane [DEPTH];
   logic [WORD_W-1:0] word;

   for (genvar r = 0; r < DEPTH; r++) begin : g_lane
      localparam logic [CTRL_W-1:0] CFIELD = CTRL_W'(rom_ctrl(r, N_OPC, IRE_BIT));
      localparam logic [ADDR_W-1:0] NFIELD = ADDR_W'(rom_next(r, N_OPC));
      assign lane[r] = sel[r] ? {CFIELD, NFIELD} : '0;
   end

   always_comb begin
      word = '0;
      for (int r = 0; r < DEPTH; r++) word = word | lane[r];
   end

   assign ctrl = word[WORD_W-1 -: CTRL_W];
   assign nxt  = word[ADDR_W-1:0];

endmodule

// File: rtl/useq_addr_regs.sv
module useq_addr_regs #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] row_nxt,
   input  logic              take_dispatch,
   input  logic [ADDR_W-1:0] dispatch_addr,
   output logic [ADDR_W-1:0] uaddr,
   output logic              strobe
);
   import useq_pkg::*;

   phase_e            phase;
   logic [ADDR_W-1:0] reg_i;
   logic [ADDR_W-1:0] reg_ii;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= PH_SELECT;
         reg_i  <= '0;
         reg_ii <= '0;
      end else if (phase == PH_SELECT) begin
         reg_ii <= take_dispatch ? dispatch_addr : row_nxt;
         phase  <= PH_TRANSFER;
      end else begin
         reg_i  <= reg_ii;
         phase  <= PH_SELECT;
      end
   end

   assign uaddr  = reg_i;
   assign strobe = (phase == PH_SELECT);

   a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
      strobe |=> $stable(uaddr));
   a_r2_phase_fall: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);
   a_r2_phase_rise: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> strobe);
   a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (uaddr == '0) && strobe);

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
   parameter int CTRL_W  = 16,
   parameter int ADDR_W  = 5,
   parameter int OPC_W   = 3,
   parameter int IRE_BIT = 15
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [OPC_W-1:0]          opcode_i,
   output logic [CTRL_W-1:0]         ctrl_o,
   output logic [ADDR_W-1:0]         uaddr_o,
   output logic [(1 << ADDR_W)-1:0]  row_sel_o,
   output logic                      strobe_o
);
   import useq_pkg::*;

   localparam int N_OPC = 1 << OPC_W;
   localparam int DEPTH = 1 << ADDR_W;

   if (CTRL_W < 16) begin : g_bad_ctrl
      $error("ucode_sequencer: CTRL_W must be at least 16");
   end
   if (OPC_W > 3) begin : g_bad_opc
      $error("ucode_sequencer: opcode field holds at most 3 bits");
   end
   if (IRE_BIT >= CTRL_W || (IRE_BIT >= 9 && IRE_BIT <= 14) || IRE_BIT <= 3) begin : g_bad_ire
      $error("ucode_sequencer: IRE_BIT collides with another control bit");
   end
   if (exec_start(N_OPC) > DEPTH) begin : g_bad_depth
      $error("ucode_sequencer: routines do not fit in the control store");
   end

   logic [ADDR_W-1:0] uaddr;
   logic              strobe;
   logic [DEPTH-1:0]  sel_raw;
   logic [DEPTH-1:0]  sel_gated;
   logic [CTRL_W-1:0] ctrl;
   logic [ADDR_W-1:0] row_nxt;
   logic [ADDR_W-1:0] disp_tab [N_OPC];
   logic [ADDR_W-1:0] dispatch_addr;

   for (genvar k = 0; k < N_OPC; k++) begin : g_disp
      assign disp_tab[k] = ADDR_W'(exec_start(k));
   end
   assign dispatch_addr = disp_tab[opcode_i];

   useq_row_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .addr      (uaddr),
      .en        (strobe),
      .sel_raw   (sel_raw),
      .sel_gated (sel_gated)
   );

   useq_ctrl_matrix #(
      .CTRL_W (CTRL_W),
      .ADDR_W (ADDR_W),
      .N_OPC  (N_OPC),
      .IRE_BIT(IRE_BIT)
   ) u_mat (
      .sel  (sel_raw),
      .ctrl (ctrl),
      .nxt  (row_nxt)
   );

   useq_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk           (clk),
      .rst           (rst),
      .row_nxt       (row_nxt),
      .take_dispatch (ctrl[IRE_BIT]),
      .dispatch_addr (dispatch_addr),
      .uaddr         (uaddr),
      .strobe        (strobe)
   );

   assign ctrl_o    = ctrl;
   assign uaddr_o   = uaddr;
   assign row_sel_o = sel_gated;
   assign strobe_o  = strobe;

   a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
      strobe_o |-> ($countones(row_sel_o) == 1) && row_sel_o[uaddr_o]);
   a_r3_sel_idle: assert property (@(posedge clk) disable iff (rst)
      !strobe_o |-> (row_sel_o == '0));
   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
      strobe_o |=> $stable(ctrl_o));
   a_r5_fetch_step: assert property (@(posedge clk) disable iff (rst)
      (strobe_o && uaddr_o == '0) |=> ##1 (uaddr_o == ADDR_W'(1)));
   a_r6_dispatch: assert property (@(posedge clk) disable iff (rst)
      (strobe_o && ctrl_o[IRE_BIT]) |=> ##1 (uaddr_o == $past(dispatch_addr, 2)));

endmodule

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  opcode = 3'd0;
   logic [15:0] ctrl;
   logic [4:0]  uaddr;
   logic [31:0] row_sel;
   logic        strobe;

   int checks = 0;
   int errors = 0;

   int m_addr = 0;
   int m_pend = 0;
   bit m_sel  = 1'b1;

   always #4 clk = ~clk;

   ucode_sequencer u_ucode_sequencer (
      .clk       (clk),
      .rst       (rst),
      .opcode_i  (opcode),
      .ctrl_o    (ctrl),
      .uaddr_o   (uaddr),
      .row_sel_o (row_sel),
      .strobe_o  (strobe)
   );

   function automatic int rlen(input int k);
      return (k % 3) + 1;
   endfunction

   function automatic int rstart(input int k);
      int s = 3;
      for (int i = 0; i < k; i++) s += rlen(i);
      return s;
   endfunction

   function automatic int exp_ctrl(input int r);
      int c = 0;
      if (r < 3) begin
         c = 1 << r;
         if (r == 2) c = c | (1 << 15);
      end else begin
         for (int k = 0; k < 8; k++)
            for (int j = 0; j < rlen(k); j++)
               if (rstart(k) + j == r)
                  c = (k << 12) | (j << 10) | 8 | ((j == rlen(k) - 1) ? 512 : 0);
      end
      return c;
   endfunction

   function automatic int exp_next(input int r);
      int n = 0;
      if (r < 2) n = r + 1;
      for (int k = 0; k < 8; k++)
         for (int j = 0; j < rlen(k) - 1; j++)
            if (rstart(k) + j == r) n = r + 1;
      return n;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_state();
      string atag;
      atag = (m_addr < 3) ? "R5 fetch row" : "R6/R7 routine row";
      check(uaddr == 5'(m_addr), atag, int'(uaddr), m_addr);
      check(strobe == m_sel, "R2 strobe phase", int'(strobe), int'(m_sel));
      check(ctrl == 16'(exp_ctrl(m_addr)), "R4 control field", int'(ctrl), exp_ctrl(m_addr));
      if (m_sel)
         check(row_sel == (32'd1 << m_addr), "R3 select one-hot", int'(row_sel), 1 << m_addr);
      else
         check(row_sel == 32'd0, "R3 select idle", int'(row_sel), 0);
   endtask

   task automatic tick(input logic [2:0] op);
      check_state();
      opcode = op;
      if (m_sel) begin
         m_pend = (m_addr == 2) ? rstart(int'(op)) : exp_next(m_addr);
         m_sel  = 1'b0;
      end else begin
         m_addr = m_pend;
         m_sel  = 1'b1;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      check(uaddr == 5'd0, "R1 reset address", int'(uaddr), 0);
      check(strobe == 1'b1, "R1 reset strobe", int'(strobe), 1);
      check(row_sel == 32'd1, "R1 reset select", int'(row_sel), 1);
      check(ctrl == 16'h0001, "R1 reset control", int'(ctrl), 1);
      rst = 1'b0;

      // steady opcode per instruction: every dispatch target and routine length (R6, R7)
      for (int k = 0; k < 8; k++) begin
         for (int t = 0; t < 2 * (3 + rlen(k)); t++) tick(3'(k));
         check(uaddr == 5'd0 && strobe, "R7 return to fetch", int'(uaddr), 0);
      end

      // R8: correct opcode only at the dispatch edge, complement elsewhere
      for (int k = 0; k < 8; k++) begin
         for (int t = 0; t < 2 * (3 + rlen(k)); t++)
            tick((m_sel && m_addr == 2) ? 3'(k) : 3'(7 - k));
         check(uaddr == 5'd0 && strobe, "R8 opcode ignored off-edge", int'(uaddr), 0);
      end

      // scrambled opcode on every clock
      for (int t = 0; t < 150; t++) tick(3'((t * 5 + 3 + (t >> 3)) % 8));

      // R1: reset in the middle of an instruction
      while (m_addr < 3) tick(3'd5);
      tick(3'd5);
      rst = 1'b1;
      @(negedge clk);
      check(uaddr == 5'd0, "R1 mid-run reset address", int'(uaddr), 0);
      check(strobe == 1'b1, "R1 mid-run reset strobe", int'(strobe), 1);
      check(ctrl == 16'h0001, "R1 mid-run reset control", int'(ctrl), 1);
      rst = 1'b0;
      m_addr = 0;
      m_sel  = 1'b1;
      for (int t = 0; t < 2 * (3 + rlen(4)); t++) tick(3'd4);
      check(uaddr == 5'd0 && strobe, "R7 return after reset", int'(uaddr), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule